// File: doc/BRIEF.md
# Strobed Sample Capture Buffer

This block records bytes from a parallel data bus into an internal memory of 32 slots. A separate data-ready strobe, which may change at any time relative to the clock, marks each new byte. On every rising edge of that strobe, the byte on the bus is stored in the next free slot, starting at slot 0. A running count of stored bytes is kept on an output.

The buffer is single-use. When the last slot is written, a full flag goes high. From then on, strobes are ignored until a synchronous reset clears the count and the flag. The memory contents are not cleared by reset. A combinational read port returns the byte in any slot selected by a 5-bit address. This lets a host or a testbench fetch the captured record.

The strobe is first synchronized to the clock and then edge-detected, which adds a fixed latency. The data bus must hold its value from the strobe's rising edge until the capture takes effect, which is at least three clock cycles.

Top module: `strobe_capture_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, the sample count is 0 and the full flag is low.
- R2: A strobe held high for many cycles causes exactly one capture. The count rises by one, not once per cycle.
- R3: Captured bytes fill the slots in order from slot 0 upward. The read port returns the byte stored at the slot given by the read address, with no clock delay.
- R4: Each accepted rising edge raises the count by exactly one. The count never skips and never exceeds 32. Timing: the strobe is sampled high at clock edge N. The count is unchanged after edge N+1 and has risen after edge N+2, which is the third edge (two synchronizer flops plus one edge stage). The bus byte present at that third edge is the one stored.
- R5: The full flag is high exactly when the count equals 32. With 31 samples stored it is still low.
- R6: While the full flag is high, rising edges of the strobe change neither the count nor any stored byte.
- R7: Falling edges of the strobe, a strobe held low, and changes on the data bus while the strobe does not rise cause no capture and leave the count unchanged.
- R8: A reset in the middle of filling returns the count to 0 and the flag to low. The next capture writes slot 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobeAsync | input | 1 | Data-ready strobe, not synchronized to the clock |
| dataIn | input | 8 | Parallel data bus sampled on capture |
| rdAddr | input | 5 | Slot address for the read port |
| rdData | output | 8 | Byte stored at `rdAddr` (combinational) |
| sampleCount | output | 6 | Number of stored samples, 0 to 32 |
| bufFull | output | 1 | High once all 32 slots are written |

## Verification
Strobes are driven with high and low phases of varying length, including one held high for many cycles. This separates edge detection from level detection. Each captured byte is different, so a write to the wrong slot or a capture from the wrong cycle shows up on readback. Data changes while the strobe stays low, and extra strobes after the buffer is full, check that nothing is written when it should not be. A fill cut short by reset shows that slot 0 is reused.

// File: rtl/strobe_capture_pkg.sv
package strobe_capture_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // store dataIn at the current write slot this cycle
  } capCtl_t;
endpackage

// File: rtl/strobe_capture_ctrl.sv
module strobe_capture_ctrl
  import strobe_capture_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobeAsync,
  output capCtl_t          ctl,
  output logic [IDX_W-1:0] wrIdx,
  output logic [CNT_W-1:0] sampleCount,
  output logic             bufFull
);
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   strobeSeen;
  logic                   strobeRise;
  logic [CNT_W-1:0]       countQ;
  logic                   fullQ;

  // Synchronizer chain followed by one edge-detect stage
  always_ff @(posedge clk) begin
    if (rst) begin
      syncPipe   <= '0;
      strobeSeen <= 1'b0;
    end else begin
      syncPipe   <= {syncPipe[SYNC_STAGES-2:0], strobeAsync};
      strobeSeen <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign strobeRise = syncPipe[SYNC_STAGES-1] & ~strobeSeen;
  assign ctl.wrEn   = strobeRise & ~fullQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
      fullQ  <= 1'b0;
    end else if (ctl.wrEn) begin
      countQ <= countQ + CNT_W'(1);
      if (countQ == CNT_W'(DEPTH - 1)) fullQ <= 1'b1;
    end
  end

  assign wrIdx       = countQ[IDX_W-1:0];
  assign sampleCount = countQ;
  assign bufFull     = fullQ;
endmodule

// File: rtl/strobe_capture_dp.sv
module strobe_capture_dp
  import strobe_capture_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  capCtl_t           ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrIdx] <= dataIn;
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/strobe_capture_buf.sv
module strobe_capture_buf
  import strobe_capture_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeAsync,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  sampleCount,
  output logic              bufFull
);
  capCtl_t          capCtl;
  logic [IDX_W-1:0] wrIdx;

  strobe_capture_ctrl #(
    .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strobeAsync(strobeAsync),
    .ctl(capCtl), .wrIdx(wrIdx),
    .sampleCount(sampleCount), .bufFull(bufFull)
  );

  strobe_capture_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .ctl(capCtl), .wrIdx(wrIdx),
    .dataIn(dataIn), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/strobe_capture_buf_chk.sv
module strobe_capture_buf_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] sampleCount,
  input logic             bufFull
);
  // R4: count moves by zero or one per cycle
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sampleCount == $past(sampleCount) ||
                     sampleCount == $past(sampleCount) + CNT_W'(1)));

  // R4: count is bounded by the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sampleCount <= CNT_W'(DEPTH));

  // R5: full flag tracks count reaching depth
  a_r5_full_at_depth: assert property (@(posedge clk) disable iff (rst)
    bufFull == (sampleCount == CNT_W'(DEPTH)));

  // R6: once full, count is frozen
  a_r6_frozen_when_full: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bufFull)) |-> (bufFull && $stable(sampleCount)));
endmodule

bind strobe_capture_buf strobe_capture_buf_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .sampleCount(sampleCount), .bufFull(bufFull)
);

// File: tb/strobe_capture_buf_bench.sv
module strobe_capture_buf_bench;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst;
  logic       strobeAsync;
  logic [7:0] dataIn;
  logic [4:0] rdAddr;
  logic [7:0] rdData;
  logic [5:0] sampleCount;
  logic       bufFull;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  logic [7:0] model [DEPTH];
  int expCount = 0;
  int lastCnt = 0;
  bit monOn = 1'b1;

  always #10 clk = ~clk;

  strobe_capture_buf u_strobe_capture_buf (
    .clk(clk), .rst(rst), .strobeAsync(strobeAsync), .dataIn(dataIn),
    .rdAddr(rdAddr), .rdData(rdData), .sampleCount(sampleCount),
    .bufFull(bufFull)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one strobe pulse, expected byte pushed to scoreboard when space remains
  task automatic sendSample(input logic [7:0] d, input int hi, input int lo);
    @(negedge clk);
    dataIn = d;
    strobeAsync = 1'b1;
    if (expCount < DEPTH) begin
      expQ.push_back(d);
      model[expCount] = d;
      expCount++;
    end
    repeat (hi) @(negedge clk);
    strobeAsync = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic readBack(input int n, input string req);
    monOn = 1'b0;
    for (int i = 0; i < n; i++) begin
      rdAddr = 5'(i);
      #1;
      check(rdData == model[i], req, $sformatf("slot %0d", i), rdData, model[i]);
    end
    monOn = 1'b1;
  endtask

  // Monitor: each count step pops one expected byte and compares the new slot
  always @(negedge clk) begin
    if (rst) lastCnt = 0;
    else if (sampleCount != 6'(lastCnt)) begin
      if (monOn) begin
        check(int'(sampleCount) == lastCnt + 1, "R4", "count step",
              sampleCount, lastCnt + 1);
        if (expQ.size() == 0)
          check(1'b0, "R6", "unexpected capture", sampleCount, lastCnt);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          rdAddr = 5'(lastCnt);
          #1;
          check(rdData == e, "R3", $sformatf("slot %0d data", lastCnt), rdData, e);
        end
      end
      lastCnt = sampleCount;
    end
  end

  initial begin
    #(20 * 100000);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; strobeAsync = 1'b0; dataIn = 8'h00; rdAddr = '0;
    repeat (3) @(negedge clk);
    check(sampleCount == 0, "R1", "count in reset", sampleCount, 0);
    check(bufFull == 0, "R1", "full in reset", bufFull, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sampleCount == 0, "R1", "count after reset", sampleCount, 0);

    // R7: data changes with strobe low capture nothing
    for (int i = 0; i < 6; i++) begin dataIn = 8'(i * 19 + 3); @(negedge clk); end
    check(sampleCount == 0, "R7", "no capture on data toggles", sampleCount, 0);

    // R4 latency, R2 long high, R7 falling edge
    dataIn = 8'hA5; strobeAsync = 1'b1;
    expQ.push_back(8'hA5); model[0] = 8'hA5; expCount = 1;
    @(negedge clk); @(negedge clk);
    check(sampleCount == 0, "R4", "count after two edges", sampleCount, 0);
    @(negedge clk);
    check(sampleCount == 1, "R4", "count after third edge", sampleCount, 1);
    dataIn = 8'h11;
    repeat (12) @(negedge clk);
    check(sampleCount == 1, "R2", "long strobe one capture", sampleCount, 1);
    strobeAsync = 1'b0;
    repeat (8) @(negedge clk);
    check(sampleCount == 1, "R7", "falling edge no capture", sampleCount, 1);

    // Fill slots 1..30 with varied pulse shapes
    for (int i = 1; i < DEPTH - 1; i++)
      sendSample(8'(i * 37) ^ 8'h5C, 3 + (i % 4), 3 + (i % 3));
    check(sampleCount == 31, "R5", "count at 31", sampleCount, 31);
    check(bufFull == 0, "R5", "not full at 31", bufFull, 0);
    sendSample(8'hE7, 4, 4);
    check(sampleCount == 32, "R5", "count at 32", sampleCount, 32);
    check(bufFull == 1, "R5", "full at 32", bufFull, 1);

    // R6: strobes while full are ignored
    for (int i = 0; i < 4; i++) sendSample(8'(8'hF0 + i), 4, 4);
    check(sampleCount == 32, "R6", "count frozen", sampleCount, 32);
    check(bufFull == 1, "R6", "full held", bufFull, 1);
    readBack(DEPTH, "R6");

    // R8: reset in mid-fill restarts at slot 0
    sendSample(8'h00, 0, 0);
    @(negedge clk);
    rst = 1'b1; strobeAsync = 1'b0;
    expQ.delete(); expCount = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sampleCount == 0, "R8", "count cleared", sampleCount, 0);
    check(bufFull == 0, "R8", "full cleared", bufFull, 0);
    sendSample(8'h3C, 5, 3);
    sendSample(8'hC3, 4, 5);
    sendSample(8'h81, 3, 3);
    check(sampleCount == 3, "R8", "count after refill", sampleCount, 3);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    expQ.delete(); expCount = 0;
    sendSample(8'h5A, 4, 4);
    sendSample(8'h96, 4, 4);
    check(sampleCount == 2, "R8", "count after second reset", sampleCount, 2);
    readBack(2, "R8");
    check(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule